// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block sits between a group of 32 lanes that issue one memory instruction together and the memory port that serves them. Each lane contributes an active bit and the byte address of a 4-byte word. The block folds the active addresses into the smallest set of naturally aligned memory transactions. Each transaction is either 32 bytes or 128 bytes long.

A request is taken on a valid/ready handshake and its addresses are stored. Transactions then leave one per cycle on a second valid/ready interface. Each carries a base address, a size flag, a mask of the lanes it satisfies, and a flag on the final one. Lanes are gathered by 128-byte segment, and segments are served in the order of the lowest-numbered lane still waiting. A segment whose lanes all fall in one 32-byte sector is sent as a 32-byte transaction. Otherwise it is sent as one 128-byte transaction.

Top module: `warp_coalescer`

## Requirements
- R1: After reset `req_ready` is 1 and `tx_valid` is 0.
- R2: A request is accepted only while `req_ready` is 1. `req_ready` falls in the cycle after a request with at least one active lane is accepted. It returns in the cycle after the last transaction is handshaken. While it is low, `req_valid` and the request inputs have no effect on the transactions.
- R3: A request whose `req_active` is all zeros produces no transaction, and `req_ready` stays 1.
- R4: Every active lane appears in exactly one transaction mask. Two active lanes share a mask exactly when their addresses agree in bits [31:7] (same 128-byte segment).
- R5: If all lanes of a transaction agree in address bits [6:5], then `tx_wide` is 0 and `tx_base` is the address with bits [4:0] cleared. Otherwise `tx_wide` is 1 and `tx_base` is the address with bits [6:0] cleared.
- R6: Transactions are issued in increasing order of the lowest-numbered lane in their mask.
- R7: `tx_last` is 1 on the final transaction of a request and 0 on every earlier one. After the final handshake `tx_valid` is 0.
- R8: While `tx_valid` is 1 and `tx_ready` is 0, the transaction outputs hold their values.
- R9: The highest-level protocol reset `rst_n` low at any time returns the block to the R1 state and discards the request in progress.
- R10: 32 active lanes reading consecutive words from a 128-byte-aligned address give a single 128-byte transaction, with mask 0xFFFFFFFF and `tx_last` set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_active | input | LANES | Active bit per lane |
| req_addr | input | LANES*AW | Byte address per lane, lane i in bits [i*AW +: AW] |
| tx_valid | output | 1 | Transaction offered |
| tx_ready | input | 1 | Memory side takes the transaction |
| tx_base | output | AW | Aligned base byte address |
| tx_wide | output | 1 | 1 = 128-byte transaction, 0 = 32-byte |
| tx_mask | output | LANES | Lanes served by this transaction |
| tx_last | output | 1 | Final transaction of the request |

## Verification
The assertions assume that `tx_ready` is a defined level in every cycle after reset. They also assume that the request inputs are only sampled at the accepting edge. Nothing is assumed about what the request inputs hold while the block is busy. The bench changes its inputs only on falling edges. It raises `req_valid` only when it intends a handshake, except in one test that drives a competing request on purpose during a transaction stream to show that it is ignored. `tx_ready` is stalled on alternate vectors, so the hold property sees real backpressure.

// File: rtl/warp_coalescer.sv
module warp_coalescer #(
  parameter int LANES        = 32,
  parameter int AW           = 32,
  parameter int WIDE_BYTES   = 128,
  parameter int NARROW_BYTES = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [LANES-1:0]    req_active,
  input  logic [LANES*AW-1:0] req_addr,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [AW-1:0]       tx_base,
  output logic                tx_wide,
  output logic [LANES-1:0]    tx_mask,
  output logic                tx_last
);

  localparam int WL = $clog2(WIDE_BYTES);
  localparam int NL = $clog2(NARROW_BYTES);
  localparam int LW = $clog2(LANES);
  localparam int SW = AW - NL;

  logic             busy;
  logic [LANES-1:0] pend;
  logic [SW-1:0]    addr_q [LANES];
  logic [LW-1:0]    lead;
  logic [SW-1:0]    lead_addr;
  logic [LANES-1:0] same_seg;
  logic [LANES-1:0] other_sec;
  logic [LANES*NL-1:0] unused_low;

  wire accept = req_valid && !busy;
  wire fire   = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      pend <= '0;
    end else if (accept) begin
      busy <= |req_active;
      pend <= req_active;
    end else if (fire) begin
      busy <= !tx_last;
      pend <= pend & ~same_seg;
    end
  end

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      always_ff @(posedge clk)
        if (accept) addr_q[i] <= req_addr[i*AW+NL +: SW];

      assign unused_low[i*NL +: NL] = req_addr[i*AW +: NL];
      assign same_seg[i]  = pend[i] && (addr_q[i][SW-1:WL-NL] == lead_addr[SW-1:WL-NL]);
      assign other_sec[i] = same_seg[i] && (addr_q[i][WL-NL-1:0] != lead_addr[WL-NL-1:0]);
    end
  endgenerate

  always_comb begin
    lead = '0;
    for (int i = LANES - 1; i >= 0; i--)
      if (pend[i]) lead = LW'(i);
  end

  assign lead_addr = addr_q[lead];
  assign req_ready = !busy;
  assign tx_valid  = busy;
  assign tx_mask   = same_seg;
  assign tx_wide   = |other_sec;
  assign tx_last   = (pend & ~same_seg) == '0;
  assign tx_base   = tx_wide ? {lead_addr[SW-1:WL-NL], {WL{1'b0}}}
                             : {lead_addr, {NL{1'b0}}};

endmodule

// File: rtl/warp_coalescer_chk.sv
module warp_coalescer_chk #(
  parameter int LANES        = 32,
  parameter int AW           = 32,
  parameter int WIDE_BYTES   = 128,
  parameter int NARROW_BYTES = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LANES-1:0] req_active,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [AW-1:0]    tx_base,
  input logic             tx_wide,
  input logic [LANES-1:0] tx_mask,
  input logic             tx_last
);
  localparam int WL = $clog2(WIDE_BYTES);
  localparam int NL = $clog2(NARROW_BYTES);

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !req_ready); // R2

  AST_EMPTY_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (req_active == '0) |=> req_ready && !tx_valid); // R3

  AST_MASK_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> tx_mask != '0); // R4

  AST_MASKS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !tx_last |=> (tx_mask & $past(tx_mask)) == '0); // R4

  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (tx_wide ? (tx_base[WL-1:0] == '0) : (tx_base[NL-1:0] == '0))); // R5

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && tx_last |=> !tx_valid && req_ready); // R7

  AST_MORE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready && !tx_last |=> tx_valid); // R7

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_base) && $stable(tx_wide)
                              && $stable(tx_mask) && $stable(tx_last)); // R8
endmodule

bind warp_coalescer warp_coalescer_chk #(
  .LANES(LANES), .AW(AW), .WIDE_BYTES(WIDE_BYTES), .NARROW_BYTES(NARROW_BYTES)
) chk (.*);

// File: tb/warp_coalescer_test.sv
`timescale 1ns/1ps
module warp_coalescer_test;
  localparam int LANES = 32;
  localparam int AW    = 32;
  localparam int NV    = 9;

  localparam int unsigned VB [NV] = '{32'h1000, 32'h2000, 32'h3010, 32'h4004, 32'h5040,
                                      32'h6100, 32'h7000, 32'h8000, 32'h9000};
  localparam int          VS [NV] = '{4, 128, 4, 0, 4, -4, 32, 36, 4};
  localparam int unsigned VA [NV] = '{32'hFFFFFFFF, 32'hFFFFFFFF, 32'h000000FF, 32'hFFFFFFFF,
                                      32'hFFFFFFFF, 32'hFFFFFFFF, 32'hAAAAAAAA, 32'h5A5A0FF0,
                                      32'h00000000};
  localparam bit          VR [NV] = '{0, 1, 0, 1, 0, 1, 0, 1, 0};

  logic                clk = 0;
  logic                rst_n = 0;
  logic                req_valid = 0;
  logic                req_ready;
  logic [LANES-1:0]    req_active = '0;
  logic [LANES*AW-1:0] req_addr = '0;
  logic                tx_valid;
  logic                tx_ready = 0;
  logic [AW-1:0]       tx_base;
  logic                tx_wide;
  logic [LANES-1:0]    tx_mask;
  logic                tx_last;

  warp_coalescer uut (.*);

  always #2.5 clk = ~clk;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [AW-1:0]    addr_v [LANES];
  logic [LANES-1:0] act_v;
  logic [AW-1:0]    e_base [LANES];
  logic             e_wide [LANES];
  logic [LANES-1:0] e_mask [LANES];
  int               e_n;

  task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic load(int unsigned base, int stride, logic [LANES-1:0] act);
    logic [LANES-1:0] pend;
    int lead;
    logic [LANES-1:0] m;
    logic w;
    for (int i = 0; i < LANES; i++) addr_v[i] = base + AW'(stride * i);
    act_v = act;
    pend = act;
    e_n = 0;
    while (pend != '0) begin
      lead = 0;
      for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
      m = '0;
      w = 0;
      for (int i = 0; i < LANES; i++)
        if (pend[i] && addr_v[i][AW-1:7] == addr_v[lead][AW-1:7]) begin
          m[i] = 1'b1;
          if (addr_v[i][6:5] != addr_v[lead][6:5]) w = 1;
        end
      e_base[e_n] = w ? {addr_v[lead][AW-1:7], 7'b0} : {addr_v[lead][AW-1:5], 5'b0};
      e_wide[e_n] = w;
      e_mask[e_n] = m;
      e_n++;
      pend &= ~m;
    end
  endtask

  task automatic drive_req(logic [LANES-1:0] act);
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = addr_v[i];
    req_active = act;
  endtask

  task automatic send();
    @(negedge clk);
    chk("R2 ready before request", 64'(req_ready), 64'd1);
    drive_req(act_v);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic check_tx(int k, string tag, bit last_ok);
    chk({tag, " valid"}, 64'(tx_valid), 64'd1);
    chk({tag, " R4 mask"}, 64'(tx_mask), 64'(e_mask[k]));
    chk({tag, " R5 base"}, 64'(tx_base), 64'(e_base[k]));
    chk({tag, " R5 size"}, 64'(tx_wide), 64'(e_wide[k]));
    if (last_ok) chk({tag, " R7 last"}, 64'(tx_last), 64'(k == e_n - 1));
  endtask

  task automatic drain(int from, int upto, bit stall, string tag);
    for (int k = from; k < upto; k++) begin
      if (stall) begin
        tx_ready = 0;
        @(negedge clk);
        check_tx(k, {tag, " R8 held"}, 1);
      end
      tx_ready = 1;
      check_tx(k, {tag, " R6 order"}, 1);
      chk("R2 busy not ready", 64'(req_ready), 64'd0);
      @(negedge clk);
      tx_ready = 0;
    end
  endtask

  task automatic finish_check(string tag);
    chk({tag, " idle valid"}, 64'(tx_valid), 64'd0);
    chk({tag, " idle ready"}, 64'(req_ready), 64'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset tx_valid", 64'(tx_valid), 64'd0);
    chk("R1 reset req_ready", 64'(req_ready), 64'd1);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      load(VB[v], VS[v], VA[v]);
      send();
      if (v == 0) chk("R10 single wide", 64'(e_n), 64'd1);
      drain(0, e_n, VR[v], (v == 0) ? "R10" : "vec");
      finish_check((e_n == 0) ? "R3" : "R7");
    end

    load(32'h5040, 4, 32'hFFFFFFFF);
    send();
    for (int i = 0; i < LANES; i++) req_addr[i*AW +: AW] = 32'hA000 + 32'(i * 256);
    req_active = 32'hFFFFFFFF;
    req_valid = 1;
    @(negedge clk);
    check_tx(0, "R2 ignored request", 1);
    tx_ready = 1;
    @(negedge clk);
    tx_ready = 0;
    req_valid = 0;
    check_tx(1, "R2 ignored request", 1);
    drain(1, e_n, 0, "R2");
    finish_check("R2");

    load(32'h2000, 128, 32'hFFFFFFFF);
    send();
    drain(0, 3, 0, "R9 pre");
    rst_n = 0;
    @(negedge clk);
    chk("R9 reset tx_valid", 64'(tx_valid), 64'd0);
    chk("R9 reset req_ready", 64'(req_ready), 64'd1);
    rst_n = 1;
    @(negedge clk);
    chk("R9 stays idle", 64'(tx_valid), 64'd0);
    load(32'h1000, 4, 32'hFFFFFFFF);
    send();
    drain(0, e_n, 0, "R9 recover");
    finish_check("R9");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule